// File: doc/BRIEF.md
# Halt-Aware Opcode Loader

This block decides when an opcode byte is pulled out of an instruction prefetch queue. It latches that byte, together with a flag that marks interrupt entry, into a 9-bit instruction register. A decode stage works on the register contents one clock after each load. That decode flags the halt opcode, flags the opcodes that finish in plain logic without microcode, and starts the microcode sequencer for every other opcode.

The block has no halt state of its own. It stays halted because the halt opcode keeps sitting in the instruction register, and the decoded halt indication stops any further bytes from being taken. A maskable or non-maskable interrupt request overrides that block. The loader then performs a load that does not pop the queue and that sets the interrupt flag. The flag suppresses normal opcode decode, so the halt indication drops, and the microcode address output takes a fixed handler entry point. Reset also ends the halt.

The microcode sequencer and the queue appear only as plain signals. `execDone` reports that a microcoded routine has finished.

Top module: `halt_load_ctrl`

## Requirements
- R1: `qTake` is high only in a cycle where the loader is idle, `qValid` is high, no interrupt request is pending and no halt is decoded. That cycle is a first-clock load, and `qByte` enters the register at the next clock edge.
- R2: The instruction register holds an 8-bit opcode plus an interrupt flag. A load caused by an interrupt request sets the flag and does not assert `qTake`, even when `qValid` is high.
- R3: Decode outputs (`halted`, `oneByteLogic`, `uStart`) reflect a loaded byte two cycles after its `qTake` cycle: one clock for the register and one for the decode stage.
- R4: Opcode 0xF4 without the interrupt flag drives `halted` and `oneByteLogic` high and keeps `uStart` low.
- R5: While `halted` is high, `qTake` stays low whatever `qValid` does.
- R6: `halted` stays high for as long as 0xF4 remains in the register. Without a request or reset it never falls.
- R7: A request on `intReq` or `nmiReq` while the loader is idle (halted or not) produces a one-cycle acknowledge (`intAck` or `nmiAck`) and a load. `halted` falls two clock edges after the acknowledge cycle.
- R8: When the interrupt flag is decoded, `uStart` pulses and `uAddr` equals `NMI_ENTRY` (default 0x002) for a non-maskable entry or `INT_ENTRY` (default 0x001) for a maskable one. When both requests are present, only `nmiAck` is given.
- R9: Opcodes 0xF5 and 0xF8 to 0xFD set `oneByteLogic` and do not assert `uStart`. The loader can take the next byte one cycle after decode.
- R10: Every other opcode pulses `uStart` with `uAddr` equal to the opcode shifted left by four bits. The loader then takes no byte until `execDone` has been high for one cycle.
- R11: After reset the register holds 0x90 with the flag clear, `halted` and `oneByteLogic` are low, and the loader is idle.
- R12: Interrupt requests are not acknowledged while a microcoded routine is running. They are acknowledged in the first idle cycle after `execDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qValid | input | 1 | Prefetch queue has a byte available |
| qByte | input | 8 | Byte at the head of the queue |
| qTake | output | 1 | Pops the head byte of the queue this cycle |
| intReq | input | 1 | Maskable interrupt request (level) |
| nmiReq | input | 1 | Non-maskable interrupt request (level) |
| intAck | output | 1 | Maskable request accepted this cycle |
| nmiAck | output | 1 | Non-maskable request accepted this cycle |
| execDone | input | 1 | Microcoded routine has finished |
| halted | output | 1 | Halt opcode decoded |
| oneByteLogic | output | 1 | Decoded opcode completes in logic |
| uStart | output | 1 | Start microcode at `uAddr` |
| uAddr | output | UA_W | Microcode start address |

## Verification
The bench drives inputs on the falling edge and reads outputs 1 ns later. It therefore counts every rising edge between a stimulus and its result.

Acknowledges and `qTake` are combinational and are read in the same cycle as the stimulus. `halted`, `oneByteLogic`, `uStart` and `uAddr` are read exactly two falling edges after the take or acknowledge cycle, and one edge earlier the bench confirms they have not yet changed.

Queue blocking is probed by raising `qValid` and then dropping it again before the next rising edge. This reads `qTake` without consuming a byte.

// File: rtl/ldh_pkg.sv
package ldh_pkg;
  localparam int OP_W = 8;
  localparam int IR_W = OP_W + 1;

  typedef enum logic [1:0] {
    LD_WAIT,
    LD_LOADED,
    LD_EXEC,
    LD_MICRO
  } ldState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadIr;
    logic irqEntry;
    logic nmiEntry;
  } ldStrobe_t;
endpackage

// File: rtl/ldh_ctl.sv
module ldh_ctl
  import ldh_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      qValid,
  input  logic      intReq,
  input  logic      nmiReq,
  input  logic      execDone,
  input  logic      decHalt,
  input  logic      dec1bl,
  input  logic      decInt,
  output logic      qTake,
  output logic      intAck,
  output logic      nmiAck,
  output logic      uStart,
  output ldStrobe_t stb
);
  ldState_t state, stateNext;
  logic irqPend, inWait, firstClock, needMicro;

  always_comb begin
    irqPend    = intReq | nmiReq;
    inWait     = (state == LD_WAIT);
    // a pending request overrides the blocked queue
    firstClock = inWait & (irqPend | (qValid & ~decHalt));
    qTake      = firstClock & ~irqPend;
    nmiAck     = inWait & nmiReq;
    intAck     = inWait & intReq & ~nmiReq;
    stb.loadIr   = firstClock;
    stb.irqEntry = inWait & irqPend;
    stb.nmiEntry = inWait & nmiReq;
    needMicro  = decInt | (~decHalt & ~dec1bl);
    uStart     = (state == LD_EXEC) & needMicro;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      LD_WAIT:   if (firstClock) stateNext = LD_LOADED;
      LD_LOADED: stateNext = LD_EXEC;
      LD_EXEC:   stateNext = needMicro ? LD_MICRO : LD_WAIT;
      LD_MICRO:  if (execDone) stateNext = LD_WAIT;
      default:   stateNext = LD_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= LD_WAIT;
    else       state <= stateNext;
  end

  AST_NO_TAKE_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    decHalt |-> !qTake); // R5
  AST_HALT_NO_USTART: assert property (@(posedge clk) disable iff (!rstN)
    decHalt |-> !uStart); // R4
  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({qTake, intAck, nmiAck})); // R7
  AST_MICRO_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (state == LD_MICRO) |-> !(intAck || nmiAck || qTake)); // R12
endmodule

// File: rtl/ldh_dp.sv
module ldh_dp
  import ldh_pkg::*;
#(
  parameter int          UA_W      = 12,
  parameter logic [7:0]  HALT_OP   = 8'hF4,
  parameter logic [7:0]  RESET_OP  = 8'h90,
  parameter logic [UA_W-1:0] INT_ENTRY = 12'h001,
  parameter logic [UA_W-1:0] NMI_ENTRY = 12'h002
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] qByte,
  input  ldStrobe_t       stb,
  output logic            decHalt,
  output logic            dec1bl,
  output logic            decInt,
  output logic [UA_W-1:0] uAddr
);
  localparam int UA_PAD = UA_W - OP_W;

  logic [IR_W-1:0] ir, irDec;
  logic            nmiSel, loadedLast;
  logic [OP_W-1:0] op;

  function automatic logic isLogicOp(input logic [OP_W-1:0] o);
    return (o == HALT_OP) || (o == 8'hF5) || (o >= 8'hF8 && o <= 8'hFD);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ir         <= {1'b0, RESET_OP};
      irDec      <= {1'b0, RESET_OP};
      nmiSel     <= 1'b0;
      loadedLast <= 1'b0;
    end else begin
      if (stb.loadIr) begin
        ir     <= stb.irqEntry ? {1'b1, {OP_W{1'b0}}} : {1'b0, qByte};
        nmiSel <= stb.nmiEntry;
      end
      irDec      <= ir;  // one clock to reach decode
      loadedLast <= stb.loadIr;
    end
  end

  always_comb begin
    decInt  = irDec[IR_W-1];
    op      = irDec[OP_W-1:0];
    decHalt = ~decInt & (op == HALT_OP);
    dec1bl  = ~decInt & isLogicOp(op);
    if (decInt) uAddr = nmiSel ? NMI_ENTRY : INT_ENTRY;
    else        uAddr = {op, {UA_PAD{1'b0}}};
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (decHalt && !stb.loadIr && !loadedLast) |=> decHalt); // R6
  AST_INT_CLEARS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (loadedLast && ir[IR_W-1]) |=> !decHalt); // R7
endmodule

// File: rtl/halt_load_ctrl.sv
module halt_load_ctrl
  import ldh_pkg::*;
#(
  parameter int UA_W = 12,
  parameter logic [UA_W-1:0] INT_ENTRY = 12'h001,
  parameter logic [UA_W-1:0] NMI_ENTRY = 12'h002
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            qValid,
  input  logic [7:0]      qByte,
  output logic            qTake,
  input  logic            intReq,
  input  logic            nmiReq,
  output logic            intAck,
  output logic            nmiAck,
  input  logic            execDone,
  output logic            halted,
  output logic            oneByteLogic,
  output logic            uStart,
  output logic [UA_W-1:0] uAddr
);
  ldStrobe_t stb;
  logic decHalt, dec1bl, decInt;

  ldh_ctl u_ctl (
    .clk(clk), .rstN(rstN), .qValid(qValid), .intReq(intReq), .nmiReq(nmiReq),
    .execDone(execDone), .decHalt(decHalt), .dec1bl(dec1bl), .decInt(decInt),
    .qTake(qTake), .intAck(intAck), .nmiAck(nmiAck), .uStart(uStart), .stb(stb)
  );

  ldh_dp #(.UA_W(UA_W), .INT_ENTRY(INT_ENTRY), .NMI_ENTRY(NMI_ENTRY)) u_dp (
    .clk(clk), .rstN(rstN), .qByte(qByte), .stb(stb),
    .decHalt(decHalt), .dec1bl(dec1bl), .decInt(decInt), .uAddr(uAddr)
  );

  assign halted       = decHalt;
  assign oneByteLogic = dec1bl;
endmodule

// File: tb/sim_halt_load_ctrl.sv
module sim_halt_load_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic qValid = 1'b0, intReq = 1'b0, nmiReq = 1'b0, execDone = 1'b0;
  logic [7:0] qByte = 8'h00;
  logic qTake, intAck, nmiAck, halted, oneByteLogic, uStart;
  logic [11:0] uAddr;
  int nChk = 0, nFail = 0;

  always #10 clk = ~clk;

  halt_load_ctrl u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // read qTake without consuming a byte
  task automatic probeTake(input string req, input int exp);
    qValid = 1'b1; #1;
    chk(req, qTake, exp);
    qValid = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b, input string req);
    @(negedge clk); qValid = 1'b1; qByte = b; #1;
    chk(req, qTake, 1);
    @(negedge clk); qValid = 1'b0; #1;
  endtask

  task automatic finishMicro();
    @(negedge clk); execDone = 1'b1;
    @(negedge clk); execDone = 1'b0;
  endtask

  task automatic tReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; #1;
    chk("R11 halted", halted, 0);
    chk("R11 1bl", oneByteLogic, 0);
    chk("R11 uStart", uStart, 0);
    probeTake("R11 idle take", 1);
  endtask

  task automatic tNormal();
    feed(8'h40, "R1 take");
    chk("R3 no early uStart", uStart, 0);
    @(negedge clk); #1;
    chk("R10 uStart", uStart, 1);
    chk("R10 uAddr", uAddr, 12'h400);
    @(negedge clk); #1;
    probeTake("R10 busy no take", 0);
    @(negedge clk); intReq = 1'b1; #1;
    chk("R12 no ack busy", intAck, 0);
    execDone = 1'b1;
    @(negedge clk); execDone = 1'b0; #1;
    chk("R12 ack after done", intAck, 1);
    @(negedge clk); intReq = 1'b0;
    @(negedge clk); #1;
    chk("R8 int entry", uAddr, 12'h001);
    finishMicro(); #1;
    probeTake("R10 take after done", 1);
  endtask

  task automatic tFlag();
    feed(8'hF8, "R1 take flag op");
    @(negedge clk); #1;
    chk("R9 1bl", oneByteLogic, 1);
    chk("R9 no uStart", uStart, 0);
    chk("R9 not halted", halted, 0);
    @(negedge clk); #1;
    probeTake("R9 take next", 1);
  endtask

  task automatic doHalt();
    feed(8'hF4, "R1 take halt");
    chk("R3 halt latency", halted, 0);
    @(negedge clk); #1;
    chk("R4 halted", halted, 1);
    chk("R4 1bl", oneByteLogic, 1);
    chk("R4 no uStart", uStart, 0);
  endtask

  task automatic tHaltHold();
    doHalt();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      probeTake("R5 no take halted", 0);
      chk("R6 halt held", halted, 1);
    end
  endtask

  task automatic tExit(input bit useNmi);
    @(negedge clk);
    intReq = 1'b1; nmiReq = useNmi; qValid = 1'b1; #1;
    chk("R2 no pop on irq", qTake, 0);
    chk("R7 int ack", intAck, useNmi ? 0 : 1);
    chk("R8 nmi ack", nmiAck, useNmi ? 1 : 0);
    @(negedge clk); intReq = 1'b0; nmiReq = 1'b0; qValid = 1'b0; #1;
    chk("R7 still halted", halted, 1);
    @(negedge clk); #1;
    chk("R7 halt dropped", halted, 0);
    chk("R8 uStart", uStart, 1);
    chk("R8 entry", uAddr, useNmi ? 12'h002 : 12'h001);
    finishMicro(); #1;
    probeTake("R7 queue resumes", 1);
  endtask

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); rstN = 1'b1; #1;
    chk("R11 reset halted", halted, 0);
    chk("R11 reset 1bl", oneByteLogic, 0);
    tNormal();
    tFlag();
    tHaltHold();
    tExit(1'b0);
    doHalt();
    tExit(1'b1);
    doHalt();
    tReset();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule